// File: doc/BRIEF.md
# Speculative Transactional Store Buffer

This block sits beside a core's load/store path and holds every store issued inside a hardware transaction in a small private buffer organised by 64-byte line. While the transaction runs, nothing reaches the memory side. A load during the transaction looks in the buffer first. Bytes the transaction has already written come from the buffer, and all other bytes come from the memory data supplied alongside the request. When the transaction aborts, every held line is dropped in a single cycle.

On commit, the buffered lines leave through a drain port as one burst with no gaps. There is one line per cycle, in the order the lines were first written, and the final beat is flagged. The burst cannot be stopped. While it runs, the core port reports busy and ignores requests and new begins. The buffer holds a fixed number of lines, set by a parameter. A store that would need one more line ends the transaction as an abort and raises an overflow flag. The buffer does not stall or evict.

Top module: `txn_wbuf`

## Requirements
- R1: While a transaction is active, no store reaches the drain port: dr_valid stays 0 until a commit is accepted.
- R2: A store whose line (address bits [ADDR_W-1:6]) is already buffered merges into that entry. Its enabled bytes (cp_be bit k selects byte k of the 8-byte word at address bits [5:3]) overwrite the older ones and set their mask bits. It takes no new entry.
- R3: A load (cp_valid=1, cp_we=0) during an active transaction that hits a buffered line returns on cp_rdata, in the same cycle, the buffered byte where that byte's mask bit is set and the cp_mem_rdata byte elsewhere. A miss returns cp_mem_rdata unchanged.
- R4: A commit with N>0 held lines drives N consecutive drain beats, starting the cycle after the commit edge and in first-write order. Each beat carries the line number, 512 bits of data (byte j at bits 8j+7:8j) and a 64-bit byte mask. dr_last is 1 only on the final beat.
- R5: A commit with an empty buffer produces no drain beat and ends the transaction on the next cycle.
- R6: An abort discards all held lines in one cycle. Later loads miss, and a later transaction drains only its own stores.
- R7: A store needing a new line while LINES lines are held aborts the transaction, drops every line and sets tx_overflow. A store merging into a held line while full does not. tx_overflow clears when the next begin is accepted.
- R8: While draining, cp_busy is 1, tx_begin is refused and core requests are ignored.
- R9: In one cycle of an active transaction, abort takes priority over commit, and commit takes priority over a store (the store is dropped).
- R10: Outside a transaction, stores and commits have no effect, and loads return cp_mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | Commit the running transaction |
| tx_abort | input | 1 | Abort the running transaction |
| tx_active | output | 1 | A transaction is running |
| tx_overflow | output | 1 | Last transaction ended by capacity overflow |
| cp_valid | input | 1 | Core request valid |
| cp_we | input | 1 | 1 = store, 0 = load |
| cp_addr | input | ADDR_W | Byte address (bits [2:0] ignored) |
| cp_be | input | 8 | Store byte enables |
| cp_wdata | input | 64 | Store data |
| cp_mem_rdata | input | 64 | Memory word for the current load address |
| cp_rdata | output | 64 | Load result |
| cp_busy | output | 1 | Drain in progress |
| dr_valid | output | 1 | Drain beat valid |
| dr_line | output | ADDR_W-6 | Line number of the beat |
| dr_data | output | 512 | Line data |
| dr_mask | output | 64 | Byte mask |
| dr_last | output | 1 | Final beat of the burst |

## Verification
The bench sweeps the number of held lines from zero to full capacity. A design that counted beats wrongly would emit an extra beat, stop early or misplace dr_last, and one that leaked an empty commit into a drain would show a stray beat. Repeated partial stores to one word test the merge: a wrong design would either take a second entry, which shows as an extra beat, or lose older bytes. Loads against a distinct memory pattern expose a mux that ignores the mask. The bench also drives abort, commit and store together, a store at exactly full capacity to both a held and a new line, and begins during a drain. These catch wrong priority, an off-by-one in the capacity test and a begin that sneaks in before the burst ends.

// File: rtl/txn_wbuf_pkg.sv
package txn_wbuf_pkg;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int WIDX_W     = $clog2(WORDS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } tx_state_e;
endpackage

// File: rtl/txn_wbuf_match.sv
module txn_wbuf_match #(
    parameter int LINES = 8,
    parameter int TAG_W = 14,
    parameter int CW    = 4,
    parameter int IW    = 3
) (
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [CW-1:0]               count,
    input  logic [TAG_W-1:0]            probe,
    output logic [LINES-1:0]            hit_vec,
    output logic                        hit,
    output logic [IW-1:0]               hit_idx
);
    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign hit_vec[i] = (CW'(i) < count) && (tags[i] == probe);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/txn_wbuf_bytes.sv
module txn_wbuf_bytes
    import txn_wbuf_pkg::*;
(
    input  logic [LINE_BYTES*8-1:0] old_data,
    input  logic [LINE_BYTES-1:0]   old_mask,
    input  logic [WIDX_W-1:0]       widx,
    input  logic [WORD_BYTES-1:0]   be,
    input  logic [63:0]             wdata,
    input  logic [63:0]             mem_word,
    output logic [LINE_BYTES*8-1:0] new_data,
    output logic [LINE_BYTES-1:0]   new_mask,
    output logic [63:0]             rd_word
);
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_wr
        localparam int W = b / WORD_BYTES;
        localparam int K = b % WORD_BYTES;
        logic take;
        assign take = (widx == WIDX_W'(W)) && be[K];
        assign new_mask[b]        = old_mask[b] | take;
        assign new_data[b*8 +: 8] = take ? wdata[K*8 +: 8] : old_data[b*8 +: 8];
    end

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_rd
        logic [OFS_W-1:0] pos;
        assign pos = {widx, 3'(k)};
        assign rd_word[k*8 +: 8] = old_mask[pos] ? old_data[pos*8 +: 8]
                                                 : mem_word[k*8 +: 8];
    end
endmodule

// File: rtl/txn_wbuf.sv
module txn_wbuf
    import txn_wbuf_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_begin,
    input  logic                    tx_commit,
    input  logic                    tx_abort,
    output logic                    tx_active,
    output logic                    tx_overflow,
    input  logic                    cp_valid,
    input  logic                    cp_we,
    input  logic [ADDR_W-1:0]       cp_addr,
    input  logic [7:0]              cp_be,
    input  logic [63:0]             cp_wdata,
    input  logic [63:0]             cp_mem_rdata,
    output logic [63:0]             cp_rdata,
    output logic                    cp_busy,
    output logic                    dr_valid,
    output logic [ADDR_W-OFS_W-1:0] dr_line,
    output logic [LINE_BYTES*8-1:0] dr_data,
    output logic [LINE_BYTES-1:0]   dr_mask,
    output logic                    dr_last
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int CW    = $clog2(LINES + 1);
    localparam int IW    = $clog2(LINES);
    localparam int DW    = LINE_BYTES * 8;

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] didx;
        logic          ovf;
    } ctl_t;

    ctl_t                          c_d, c_q;
    logic [LINES-1:0][TAG_W-1:0]   tag_d, tag_q;
    logic [LINES-1:0][DW-1:0]      dat_d, dat_q;
    logic [LINES-1:0][LINE_BYTES-1:0] msk_d, msk_q;

    logic [TAG_W-1:0]  probe;
    logic [WIDX_W-1:0] widx;
    logic [LINES-1:0]  hit_vec;
    logic              hit;
    logic [IW-1:0]     hit_idx;
    logic [DW-1:0]     sel_data, upd_data;
    logic [LINE_BYTES-1:0] sel_mask, upd_mask;
    logic [63:0]       merged;
    logic [IW-1:0]     aidx, didx_s;

    assign probe  = cp_addr[ADDR_W-1:OFS_W];
    assign widx   = cp_addr[OFS_W-1:3];
    assign aidx   = c_q.cnt[IW-1:0];
    assign didx_s = c_q.didx[IW-1:0];

    txn_wbuf_match #(.LINES(LINES), .TAG_W(TAG_W), .CW(CW), .IW(IW)) u_match (
        .tags(tag_q), .count(c_q.cnt), .probe(probe),
        .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
    );

    assign sel_data = hit ? dat_q[hit_idx] : '0;
    assign sel_mask = hit ? msk_q[hit_idx] : '0;

    txn_wbuf_bytes u_bytes (
        .old_data(sel_data), .old_mask(sel_mask), .widx(widx), .be(cp_be),
        .wdata(cp_wdata), .mem_word(cp_mem_rdata),
        .new_data(upd_data), .new_mask(upd_mask), .rd_word(merged)
    );

    always_comb begin
        c_d   = c_q;
        tag_d = tag_q;
        dat_d = dat_q;
        msk_d = msk_q;
        case (c_q.st)
            ST_IDLE: begin
                if (tx_begin) begin
                    c_d.st  = ST_RUN;
                    c_d.cnt = '0;
                    c_d.ovf = 1'b0;
                end
            end
            ST_RUN: begin
                if (tx_abort) begin
                    c_d.st  = ST_IDLE;
                    c_d.cnt = '0;
                end else if (tx_commit) begin
                    c_d.didx = '0;
                    c_d.st   = (c_q.cnt == '0) ? ST_IDLE : ST_DRAIN;
                end else if (cp_valid && cp_we) begin
                    if (hit) begin
                        dat_d[hit_idx] = upd_data;
                        msk_d[hit_idx] = upd_mask;
                    end else if (c_q.cnt == CW'(LINES)) begin
                        c_d.st  = ST_IDLE;
                        c_d.cnt = '0;
                        c_d.ovf = 1'b1;
                    end else begin
                        tag_d[aidx] = probe;
                        dat_d[aidx] = upd_data;
                        msk_d[aidx] = upd_mask;
                        c_d.cnt     = c_q.cnt + CW'(1);
                    end
                end
            end
            ST_DRAIN: begin
                if (c_q.didx + CW'(1) == c_q.cnt) begin
                    c_d.st  = ST_IDLE;
                    c_d.cnt = '0;
                end else begin
                    c_d.didx = c_q.didx + CW'(1);
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, cnt: '0, didx: '0, ovf: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
        dat_q <= dat_d;
        msk_q <= msk_d;
    end

    assign tx_active   = (c_q.st == ST_RUN);
    assign tx_overflow = c_q.ovf;
    assign cp_busy     = (c_q.st == ST_DRAIN);
    assign cp_rdata    = (tx_active && hit) ? merged : cp_mem_rdata;
    assign dr_valid    = cp_busy;
    assign dr_line     = tag_q[didx_s];
    assign dr_data     = dat_q[didx_s];
    assign dr_mask     = msk_q[didx_s];
    assign dr_last     = cp_busy && (c_q.didx + CW'(1) == c_q.cnt);

    p_no_drain_in_txn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !dr_valid);
    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    p_burst_gapless_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_last) |=> dr_valid);
    p_abort_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_abort) |=> (!tx_active && !dr_valid && c_q.cnt == '0));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(LINES));
    p_ovf_ends_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_overflow) |-> !tx_active);
    p_busy_refuses_begin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cp_busy |=> !tx_active);
endmodule

// File: tb/txn_wbuf_test.sv
module txn_wbuf_test;
    localparam int LINES  = 8;
    localparam int ADDR_W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_begin = 0, tx_commit = 0, tx_abort = 0;
    logic tx_active, tx_overflow;
    logic cp_valid = 0, cp_we = 0;
    logic [ADDR_W-1:0] cp_addr = '0;
    logic [7:0]  cp_be = '0;
    logic [63:0] cp_wdata = '0, cp_mem_rdata = '0;
    logic [63:0] cp_rdata;
    logic cp_busy, dr_valid, dr_last;
    logic [ADDR_W-7:0] dr_line;
    logic [511:0] dr_data;
    logic [63:0]  dr_mask;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] mb [LINES][64];
    logic       mm [LINES][64];
    int         mline [LINES];

    always #10 clk = ~clk;

    txn_wbuf #(.LINES(LINES), .ADDR_W(ADDR_W)) uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic mclear;
        for (int s = 0; s < LINES; s++)
            for (int j = 0; j < 64; j++) begin mb[s][j] = 8'h00; mm[s][j] = 1'b0; end
    endtask

    task automatic store(input int line, input int w, input logic [7:0] be, input logic [63:0] d);
        cp_valid = 1; cp_we = 1; cp_addr = ADDR_W'(line * 64 + w * 8); cp_be = be; cp_wdata = d;
        tick();
        cp_valid = 0; cp_we = 0;
    endtask

    task automatic mstore(input int s, input int w, input logic [7:0] be, input logic [63:0] d);
        for (int k = 0; k < 8; k++)
            if (be[k]) begin mm[s][w*8+k] = 1'b1; mb[s][w*8+k] = d[k*8 +: 8]; end
    endtask

    function automatic logic [63:0] exp_load(input int s, input int w, input logic [63:0] mem);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = mm[s][w*8+k] ? mb[s][w*8+k] : mem[k*8 +: 8];
        return r;
    endfunction

    task automatic load_chk(input int line, input int w, input logic [63:0] exp, input string req);
        cp_valid = 1; cp_we = 0; cp_addr = ADDR_W'(line * 64 + w * 8);
        #2;
        chk(cp_rdata == exp, req, cp_rdata, exp);
        cp_valid = 0;
    endtask

    task automatic beat_chk(input int s, input bit last, input string req);
        logic [511:0] ed;
        logic [63:0]  em;
        for (int j = 0; j < 64; j++) begin ed[j*8 +: 8] = mb[s][j]; em[j] = mm[s][j]; end
        chk(dr_valid && dr_line == (ADDR_W-6)'(mline[s]), req, 64'(dr_line), 64'(mline[s]));
        chk(dr_mask == em && dr_data == ed, req, dr_data[63:0] ^ dr_mask, ed[63:0] ^ em);
        chk(dr_last == last, req, 64'(dr_last), 64'(last));
    endtask

    task automatic pulse_begin;
        tx_begin = 1; tick(); tx_begin = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #2;
        chk(!tx_active && !cp_busy && !dr_valid && !tx_overflow, "reset R8",
            {60'd0, tx_active, cp_busy, dr_valid, tx_overflow}, 64'd0);

        // R10: activity outside a transaction
        store(40, 0, 8'hFF, 64'h1122334455667788);
        tx_commit = 1; tick(); tx_commit = 0;
        chk(!dr_valid && !tx_active, "R10 idle store/commit", 64'(dr_valid), 64'd0);
        cp_mem_rdata = 64'h0F0E0D0C0B0A0908;
        load_chk(40, 0, 64'h0F0E0D0C0B0A0908, "R10 idle load");

        // Sweep fill level 0..LINES
        for (int n = 0; n <= LINES; n++) begin
            mclear();
            pulse_begin();
            chk(tx_active, "R1 begin", 64'(tx_active), 64'd1);
            for (int s = 0; s < n; s++) begin
                int w;
                logic [63:0] d1, d2, d3;
                mline[s] = 3 + s * 5 + n * 64;
                w  = s % 8;
                d1 = {8{8'(s * 17 + n + 1)}} ^ 64'h0102030405060708;
                d2 = ~d1;
                d3 = 64'hC3 << 56;
                store(mline[s], w, 8'h0F, d1);              mstore(s, w, 8'h0F, d1);
                store(mline[s], w, 8'h3C, d2);              mstore(s, w, 8'h3C, d2);
                store(mline[s], (w + 1) % 8, 8'h80, d3);    mstore(s, (w + 1) % 8, 8'h80, d3);
                chk(!dr_valid, "R1 hidden", 64'(dr_valid), 64'd0);
            end
            cp_mem_rdata = 64'hA5A5_5A5A_E1E2_E3E4;
            for (int s = 0; s < n; s++)
                load_chk(mline[s], s % 8, exp_load(s, s % 8, cp_mem_rdata), "R3 hit merge");
            load_chk(2000, 1, cp_mem_rdata, "R3 miss");
            tx_commit = 1; tick(); tx_commit = 0;
            if (n == 0) begin
                chk(!dr_valid && !tx_active && !cp_busy, "R5 empty commit", 64'(dr_valid), 64'd0);
            end else begin
                for (int s = 0; s < n; s++) begin
                    chk(cp_busy, "R8 busy", 64'(cp_busy), 64'd1);
                    beat_chk(s, s == n - 1, "R4 R2 beat");
                    if (s == 0) begin tx_begin = 1; cp_valid = 1; cp_we = 1; cp_addr = '0; cp_be = 8'hFF; end
                    tick();
                    tx_begin = 0; cp_valid = 0; cp_we = 0;
                end
                chk(!dr_valid && !tx_active && !cp_busy, "R8 begin refused", 64'(tx_active), 64'd0);
            end
        end

        // R6 and R9: abort wins over commit
        mclear();
        pulse_begin();
        store(7, 0, 8'hFF, 64'h1); store(8, 0, 8'hFF, 64'h2); store(9, 0, 8'hFF, 64'h3);
        tx_abort = 1; tx_commit = 1; tick(); tx_abort = 0; tx_commit = 0;
        chk(!tx_active && !dr_valid, "R9 R6 abort over commit", 64'(dr_valid), 64'd0);
        pulse_begin();
        cp_mem_rdata = 64'h7777_6666_5555_4444;
        load_chk(8, 0, cp_mem_rdata, "R6 discarded");
        mline[0] = 11;
        store(11, 2, 8'h01, 64'hAB); mstore(0, 2, 8'h01, 64'hAB);
        tx_commit = 1; tick(); tx_commit = 0;
        beat_chk(0, 1'b1, "R6 only new");
        tick();
        chk(!dr_valid, "R6 single beat", 64'(dr_valid), 64'd0);

        // R9: commit wins over store in the same cycle
        mclear();
        pulse_begin();
        mline[0] = 20;
        store(20, 5, 8'hFF, 64'hDEAD_BEEF_0000_0001); mstore(0, 5, 8'hFF, 64'hDEAD_BEEF_0000_0001);
        tx_commit = 1; cp_valid = 1; cp_we = 1; cp_addr = ADDR_W'(21 * 64); cp_be = 8'hFF;
        tick(); tx_commit = 0; cp_valid = 0; cp_we = 0;
        beat_chk(0, 1'b1, "R9 commit over store");
        tick();

        // R7: overflow
        mclear();
        pulse_begin();
        for (int s = 0; s < LINES; s++) store(100 + s, 0, 8'hFF, 64'(s));
        store(100, 3, 8'h0F, 64'h5);
        chk(tx_active && !tx_overflow, "R7 merge at full", 64'(tx_overflow), 64'd0);
        store(200, 0, 8'hFF, 64'h9);
        chk(!tx_active && tx_overflow && !dr_valid, "R7 overflow abort",
            {62'd0, tx_active, tx_overflow}, 64'd1);
        tick();
        chk(!dr_valid, "R7 nothing drained", 64'(dr_valid), 64'd0);
        pulse_begin();
        chk(!tx_overflow && tx_active, "R7 flag cleared", 64'(tx_overflow), 64'd0);
        cp_mem_rdata = 64'h1234;
        load_chk(100, 0, 64'h1234, "R7 lines dropped");
        tx_commit = 1; tick(); tx_commit = 0;
        chk(!dr_valid && !tx_active, "R7 R5 empty after overflow", 64'(dr_valid), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule